// File: doc/BRIEF.md
# Demand-Gated Serial Stream Feeder

This block moves bytes from a byte-wide memory into a downstream decoder over a clocked serial link. The decoder signals with a level input whether it wants data. The feeder turns its transfer engine on only at a periodic poll that finds that input high. It turns the engine off as soon as a falling edge of the input is seen. An address engine reads consecutive bytes from the memory. Each byte is bit-reversed before it enters a shifter that shifts LSB first, so the decoder receives every byte MSB first.

Memory is consumed in aligned blocks of 2^BLK_W bytes (64 KiB by default). When the last byte of a block has been read, an interrupt is raised. The engine then pauses until the host writes the base of the next block, and that write also clears the interrupt. A byte that has started shifting is always finished, so the decoder never sees a partial byte. The poll period and the serial bit period are derived from the system clock frequency parameters.

Top module: `stream_feeder`

## Requirements
- R1: The transfer engine (`active_o`) is switched on only at a poll tick, once every CLK_HZ/POLL_HZ cycles, when the synchronised demand input is high. Because of the two-flop synchroniser, `active_o` is still 0 two clock edges after `demand_i` rises, and it is 1 within CLK_HZ/POLL_HZ+3 edges.
- R2: The third rising clock edge after `demand_i` falls clears `active_o`. The second edge does not.
- R3: A byte whose memory read has been issued is shifted out in full, even if the engine is switched off. No memory read is issued while `active_o` is 0.
- R4: Each byte appears on `sdo_o` MSB first, with one bit per rising edge of `sck_o`.
- R5: `sck_o` idles low. Each bit is low for HALF = CLK_HZ/(2*BIT_HZ) cycles and then high for HALF cycles, and `sdo_o` does not change while `sck_o` is high.
- R6: Each byte costs exactly one single-cycle `mem_re_o` pulse. `mem_data_i` is taken one cycle after the pulse, and successive reads use incrementing addresses.
- R7: The low BLK_W bits of `base_i` are ignored. The first read after a base write is at the base with those bits cleared.
- R8: `irq_o` rises when the read of the last byte of a block (low BLK_W address bits all ones) is issued. It stays high until `base_we_i` is asserted, and it is low in the cycle after that write.
- R9: While `irq_o` is high, or before any base has been written, no read is issued, even with demand high. After the next base write, streaming resumes at that base.
- R10: After reset, `sck_o`, `sdo_o`, `irq_o`, `active_o` and `mem_re_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| demand_i | input | 1 | Decoder request level, asynchronous |
| base_we_i | input | 1 | Host write strobe for the block base |
| base_i | input | ADDR_W | Block base address (low BLK_W bits ignored) |
| mem_re_o | output | 1 | Memory read strobe, one cycle per byte |
| mem_addr_o | output | ADDR_W | Memory read address |
| mem_data_i | input | 8 | Read data, valid one cycle after `mem_re_o` |
| sck_o | output | 1 | Serial clock to the decoder |
| sdo_o | output | 1 | Serial data, MSB first per byte |
| irq_o | output | 1 | Block-done interrupt, held until base write |
| active_o | output | 1 | Transfer engine enabled |

## Verification
Some properties are checked on every cycle. Reads happen only while the engine is active, and never while the block-done interrupt is pending. Read pulses are one cycle long. The interrupt holds until a base write and clears right after it. Serial data stays stable during the clock high phase. Other behaviour can only be shown by the bench scenarios. These cover poll and stop latency counted in edges, bit reversal checked against the memory contents, clearing of the low base bits, completion of a byte cut by a demand fall, and the pause and resume at a block boundary.

// File: rtl/feeder_pkg.sv
package feeder_pkg;
  function automatic logic [7:0] bit_rev8(input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[7-i];
    return r;
  endfunction
endpackage

// File: rtl/feeder_sync.sv
module feeder_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] q;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= async_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= '0;
        else         q <= {q[STAGES-2:0], async_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev <= 1'b0;
    else         prev <= q[STAGES-1];

  assign level_o = q[STAGES-1];
  assign fall_o  = prev & ~q[STAGES-1];
endmodule

// File: rtl/feeder_tick.sv
module feeder_tick #(
  parameter int PERIOD = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  logic [CW-1:0] cnt;

  assign tick_o = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
endmodule

// File: rtl/feeder_addr.sv
module feeder_addr #(
  parameter int ADDR_W = 24,
  parameter int BLK_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              fetch_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ready_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] ptr;
  logic              unused_low;

  assign unused_low = ^base_i[BLK_W-1:0];
  assign addr_o     = ptr;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ptr     <= '0;
      ready_o <= 1'b0;
      irq_o   <= 1'b0;
    end else if (base_we_i) begin
      ptr     <= {base_i[ADDR_W-1:BLK_W], {BLK_W{1'b0}}};
      ready_o <= 1'b1;
      irq_o   <= 1'b0;
    end else if (fetch_i) begin
      ptr <= ptr + 1'b1;
      if (&ptr[BLK_W-1:0]) begin // last byte of block
        ready_o <= 1'b0;
        irq_o   <= 1'b1;
      end
    end
endmodule

// File: rtl/feeder_shift.sv
module feeder_shift #(
  parameter int HALF = 125
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       sck_o,
  output logic       sdo_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic [CW-1:0] cnt;

  assign sdo_o = busy_o & sh[0];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sh <= '0; bitn <= '0; cnt <= '0; sck_o <= 1'b0; busy_o <= 1'b0;
    end else if (load_i) begin
      sh <= data_i; bitn <= '0; cnt <= '0; sck_o <= 1'b0; busy_o <= 1'b1;
    end else if (busy_o) begin
      if (cnt == CW'(HALF - 1)) begin
        cnt <= '0;
        if (!sck_o) begin
          sck_o <= 1'b1;
        end else begin
          sck_o <= 1'b0;
          if (bitn == 3'd7) busy_o <= 1'b0;
          else begin
            bitn <= bitn + 1'b1;
            sh   <= sh >> 1;
          end
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
endmodule

// File: rtl/stream_feeder.sv
module stream_feeder #(
  parameter int CLK_HZ  = 250_000_000,
  parameter int BIT_HZ  = 1_000_000,
  parameter int POLL_HZ = 1_000,
  parameter int ADDR_W  = 24,
  parameter int BLK_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              demand_i,
  input  logic              base_we_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic              sck_o,
  output logic              sdo_o,
  output logic              irq_o,
  output logic              active_o
);
  import feeder_pkg::*;

  localparam int HALF     = CLK_HZ / (2 * BIT_HZ);
  localparam int POLL_CYC = CLK_HZ / POLL_HZ;

  logic dem_lvl, dem_fall, tick, ready, busy, pend;

  feeder_sync #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni, .async_i(demand_i), .level_o(dem_lvl), .fall_o(dem_fall)
  );

  feeder_tick #(.PERIOD(POLL_CYC)) u_tick (
    .clk_i, .rst_ni, .tick_o(tick)
  );

  feeder_addr #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_addr (
    .clk_i, .rst_ni, .base_we_i, .base_i, .fetch_i(mem_re_o),
    .addr_o(mem_addr_o), .ready_o(ready), .irq_o(irq_o)
  );

  feeder_shift #(.HALF(HALF)) u_shift (
    .clk_i, .rst_ni, .load_i(pend), .data_i(bit_rev8(mem_data_i)),
    .busy_o(busy), .sck_o(sck_o), .sdo_o(sdo_o)
  );

  // fall event beats a coincident poll
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)              active_o <= 1'b0;
    else if (dem_fall)        active_o <= 1'b0;
    else if (tick && dem_lvl) active_o <= 1'b1;

  assign mem_re_o = active_o & ready & ~busy & ~pend;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) pend <= 1'b0;
    else         pend <= mem_re_o;
endmodule

// File: rtl/feeder_chk.sv
module feeder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic base_we_i,
  input logic mem_re_o,
  input logic sck_o,
  input logic sdo_o,
  input logic irq_o,
  input logic active_o
);
  a_r3_read_needs_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> active_o);

  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o);

  a_r5_sdo_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(sdo_o));

  a_r8_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !base_we_i) |=> irq_o);

  a_r8_irq_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_we_i |=> !irq_o);

  a_r9_no_read_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !mem_re_o);
endmodule

bind stream_feeder feeder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .base_we_i(base_we_i), .mem_re_o(mem_re_o),
  .sck_o(sck_o), .sdo_o(sdo_o), .irq_o(irq_o), .active_o(active_o)
);

// File: tb/sim_stream_feeder.sv
`timescale 1ns/1ps
module sim_stream_feeder;
  localparam int CLK_HZ = 1000, BIT_HZ = 100, POLL_HZ = 20;
  localparam int ADDR_W = 24, BLK_W = 4;
  localparam int HALF = CLK_HZ / (2 * BIT_HZ);
  localparam int POLL_CYC = CLK_HZ / POLL_HZ;

  typedef struct packed {
    logic [23:0] base;
    logic [23:0] start;
    logic [7:0]  n;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{24'h000040, 24'h000040, 8'd3},
    '{24'h0001A9, 24'h0001A0, 8'd5},
    '{24'h0FFFF3, 24'h0FFFF0, 8'd6},
    '{24'h00077F, 24'h000770, 8'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic demand = 1'b0, base_we = 1'b0;
  logic [ADDR_W-1:0] base = '0;
  logic mem_re, sck, sdo, irq, active;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_data = '0;

  int checks = 0, fails = 0;
  logic [7:0] rx [0:255];
  int rx_n = 0, bits = 0, re_n = 0, hi = 0;
  logic [7:0] cur = '0;
  logic sck_prev = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  stream_feeder #(.CLK_HZ(CLK_HZ), .BIT_HZ(BIT_HZ), .POLL_HZ(POLL_HZ),
                  .ADDR_W(ADDR_W), .BLK_W(BLK_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .demand_i(demand), .base_we_i(base_we),
    .base_i(base), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_data_i(mem_data), .sck_o(sck), .sdo_o(sdo), .irq_o(irq),
    .active_o(active)
  );

  function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
    return 8'((a * 37) ^ (a >> 8) ^ 24'h5B);
  endfunction

  always @(posedge clk) if (mem_re) mem_data <= pat(mem_addr);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // serial monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_re) re_n++;
      if (sck && !sck_prev) begin
        cur = {cur[6:0], sdo};
        bits++;
        hi = 1;
        if (bits % 8 == 0) begin rx[rx_n % 256] = cur; rx_n++; end
      end else if (sck) begin
        hi++;
      end else if (sck_prev) begin
        chk(hi == HALF, "R5 high phase", hi, HALF);
      end
      sck_prev = sck;
    end
  end

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_base(input logic [ADDR_W-1:0] b);
    base = b; base_we = 1'b1;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic wait_rx(input int target);
    for (int i = 0; i < 4000 && rx_n < target; i++) @(negedge clk);
  endtask

  task automatic drop_and_settle();
    demand = 1'b0;
    edges(300);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int t0, n0, r0, lat;
    edges(3);
    // R10 reset state
    chk(!sck && !sdo && !irq && !active && !mem_re, "R10 reset outputs",
        {sck, sdo, irq, active, mem_re}, 0);
    rst_n = 1'b1;
    edges(5);

    // R1 poll start, R9 no base yet
    demand = 1'b1;
    edges(2);
    chk(active == 1'b0, "R1 not yet active", active, 0);
    lat = 2;
    for (int i = 0; i < POLL_CYC + 10 && !active; i++) begin @(negedge clk); lat++; end
    chk(active && lat <= POLL_CYC + 3, "R1 poll latency", lat, POLL_CYC + 3);
    edges(100);
    chk(re_n == 0, "R9 no read without base", re_n, 0);
    // R2 stop latency
    demand = 1'b0;
    edges(2);
    chk(active == 1'b1, "R2 still active at 2 edges", active, 1);
    edges(1);
    chk(active == 1'b0, "R2 off at 3 edges", active, 0);
    edges(20);

    // vector table: R4, R6, R7
    foreach (VECS[v]) begin
      t0 = rx_n;
      write_base(VECS[v].base);
      demand = 1'b1;
      wait_rx(t0 + int'(VECS[v].n));
      drop_and_settle();
      for (int k = 0; k < int'(VECS[v].n); k++)
        chk(rx[(t0 + k) % 256] == pat(VECS[v].start + ADDR_W'(k)), "R4/R6/R7 byte",
            rx[(t0 + k) % 256], pat(VECS[v].start + ADDR_W'(k)));
    end

    // R3 demand fall in mid byte
    t0 = rx_n;
    write_base(24'h000900);
    demand = 1'b1;
    for (int i = 0; i < 2000 && bits % 8 != 3; i++) @(negedge clk);
    demand = 1'b0;
    edges(400);
    r0 = re_n;
    chk(bits % 8 == 0, "R3 whole bytes only", bits % 8, 0);
    chk(rx_n == re_n, "R3 every read shifted", rx_n, re_n);
    edges(200);
    chk(re_n == r0, "R3 no read while off", re_n, r0);

    // R8 / R9 block boundary
    t0 = rx_n;
    write_base(24'h000300);
    demand = 1'b1;
    for (int i = 0; i < 4000 && !irq; i++) @(negedge clk);
    chk(irq == 1'b1, "R8 irq at block end", irq, 1);
    edges(300);
    chk(rx_n - t0 == 16, "R9 pause after block", rx_n - t0, 16);
    chk(rx[(t0 + 15) % 256] == pat(24'h00030F), "R8 last byte",
        rx[(t0 + 15) % 256], pat(24'h00030F));
    n0 = re_n;
    edges(300);
    chk(re_n == n0 && irq, "R8/R9 held and paused", re_n, n0);
    write_base(24'h000452);
    chk(irq == 1'b0, "R8 irq cleared by write", irq, 0);
    t0 = rx_n;
    wait_rx(t0 + 2);
    chk(rx[t0 % 256] == pat(24'h000450), "R9 resume at new base",
        rx[t0 % 256], pat(24'h000450));
    drop_and_settle();
    chk(!active && !sck, "R2 idle after stop", {active, sck}, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule